// File: doc/BRIEF.md
# Long-Jump Branch Sequencer

This block sequences the two execute cycles of a three-byte conditional long jump in an 8-bit core whose program counter is 16 bits wide. The fetch logic outside the block reads the opcode and advances the counter by one. It then pulses `start` with the opcode on `opcode`. On that clock edge the block checks whether the opcode belongs to the long-jump group. If it does, the block evaluates the selected test against the accumulator, the carry flag and the output latch, and stores the single-bit result.

During the two execute cycles that follow, memory delivers the two address bytes on `mem_data`, most significant first. If the test passed, the block loads each byte into the matching half of the program counter. If it failed, the block advances the counter once per cycle. The counter then points three bytes past the opcode address. A one-cycle `done` pulse marks the last execute cycle.

The counter width, the byte width and the opcode group are parameters. The number of execute cycles equals the number of address bytes, so other widths give other lengths.

Top module: `lbr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pc_inc` and both bits of `pc_ld` are 0.
- R2: A `start` taken while idle with a group opcode (`opcode[7:4]` equal to 0xC and `opcode[2]` equal to 0) gives exactly two busy cycles, beginning with the next cycle. `done` is 1 only in the second busy cycle, and the block is idle again in the cycle after that.
- R3: The test is chosen by `opcode[1:0]`: 00 always passes, 01 passes when `qlat` is 1, 10 passes when `acc` is zero, and 11 passes when `carry` is 1. When `opcode[3]` is 1 the result is inverted, so 0xC8 never jumps.
- R4: On a passed test, `pc_ld[1]` (high half) is 1 in the first busy cycle and `pc_ld[0]` (low half) is 1 in the second. In each of these cycles `pc_wdata` equals `mem_data`, and `pc_inc` stays 0.
- R5: On a failed test, `pc_inc` is 1 in both busy cycles and `pc_ld` stays 0, so the counter ends at the opcode address plus 3, modulo 2^16.
- R6: The flags are sampled only on the `start` edge. Changing `acc`, `carry` or `qlat` during the busy cycles has no effect on the outputs.
- R7: A `start` with an opcode outside the group (other high nibble, or `opcode[2]` equal to 1) is ignored, and `busy` stays 0 in the next cycle.
- R8: A `start` that arrives while busy is ignored, and the sequence still ends after two busy cycles.
- R9: In any cycle, at most one of `pc_ld[1]`, `pc_ld[0]` and `pc_inc` is 1, and none of them is 1 while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opcode fetched this cycle |
| opcode | input | 8 | Fetched opcode |
| mem_data | input | 8 | Address byte read in the current execute cycle |
| acc | input | 8 | Accumulator value |
| carry | input | 1 | Carry flag |
| qlat | input | 1 | Output latch value |
| pc_ld | output | 2 | Per-half program-counter load, bit 1 is the high half |
| pc_wdata | output | 8 | Byte to load into the selected half |
| pc_inc | output | 1 | Program-counter increment |
| busy | output | 1 | Execute cycles in progress |
| done | output | 1 | Last execute cycle |

## Verification
The bench covers all eight group opcodes. For each one it tries four accumulator values (zero, one, only the top bit set, all ones) and all four combinations of carry and latch. This separates every test and every sense, and it catches a zero check that looks at only part of the byte. Each run inverts all the flags after the start edge, which shows whether the result really is held from the start edge. A reference program counter in the bench applies the load and increment strobes. It is compared against the target address or the skip address, including a skip that wraps past 0xFFFF. Further stimuli send rejected opcodes and a `start` that arrives during a sequence, and the bench confirms that neither one has any effect.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_EXEC = 1'b1
   } seq_state_t;

   typedef enum logic [1:0] {
      TST_ALWAYS = 2'b00,
      TST_QSET   = 2'b01,
      TST_ACCZ   = 2'b10,
      TST_CARRY  = 2'b11
   } test_sel_t;

   localparam int INV_BIT   = 3;
   localparam int SKIP_BIT  = 2;

endpackage

// File: rtl/lbr_cond.sv
module lbr_cond
   import lbr_pkg::*;
#(
   parameter int         DW       = 8,
   parameter logic [3:0] OP_GROUP = 4'hC
) (
   input  logic [7:0]    opcode,
   input  logic [DW-1:0] acc,
   input  logic          carry,
   input  logic          qlat,
   output logic          is_jump,
   output logic          take
);

   test_sel_t sel;
   logic      raw;
   logic      acc_zero;

   assign sel      = test_sel_t'(opcode[1:0]);
   assign acc_zero = (acc == '0);

   always_comb begin
      unique case (sel)
         TST_ALWAYS: raw = 1'b1;
         TST_QSET:   raw = qlat;
         TST_ACCZ:   raw = acc_zero;
         TST_CARRY:  raw = carry;
         default:    raw = 1'b0;
      endcase
   end

   assign take    = raw ^ opcode[INV_BIT];
   assign is_jump = (opcode[7:4] == OP_GROUP) && !opcode[SKIP_BIT];

endmodule

// File: rtl/lbr_fsm.sv
module lbr_fsm
   import lbr_pkg::*;
#(
   parameter int NB = 2,
   localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          take_in,
   output logic          busy,
   output logic          last,
   output logic          taken,
   output logic [IW-1:0] idx
);

   seq_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         taken <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_EXEC;
                  idx   <= IW'(NB - 1);
                  taken <= take_in;
               end
            end
            ST_EXEC: begin
               if (idx == '0) begin
                  state <= ST_IDLE;
                  taken <= 1'b0;
               end else begin
                  idx <= idx - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state == ST_EXEC);
   assign last = busy && (idx == '0);

endmodule

// File: rtl/lbr_pcdrv.sv
module lbr_pcdrv #(
   parameter int NB = 2,
   parameter int DW = 8,
   localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          busy,
   input  logic          taken,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] mem_data,
   output logic [NB-1:0] pc_ld,
   output logic [DW-1:0] pc_wdata,
   output logic          pc_inc
);

   for (genvar b = 0; b < NB; b++) begin : g_half
      assign pc_ld[b] = busy && taken && (idx == IW'(b));
   end

   assign pc_inc   = busy && !taken;
   assign pc_wdata = mem_data;

endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
   import lbr_pkg::*;
#(
   parameter int         DW       = 8,
   parameter int         AW       = 16,
   parameter logic [3:0] OP_GROUP = 4'hC,
   localparam int        NB       = AW / DW,
   localparam int        IW       = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    opcode,
   input  logic [DW-1:0] mem_data,
   input  logic [DW-1:0] acc,
   input  logic          carry,
   input  logic          qlat,
   output logic [NB-1:0] pc_ld,
   output logic [DW-1:0] pc_wdata,
   output logic          pc_inc,
   output logic          busy,
   output logic          done
);

   if (AW % DW != 0) begin : g_bad_width
      $error("lbr_seq: AW must be a multiple of DW");
   end
   if (NB < 2) begin : g_bad_count
      $error("lbr_seq: at least two address bytes required");
   end

   logic          is_jump;
   logic          take;
   logic          taken;
   logic          last;
   logic [IW-1:0] idx;

   lbr_cond #(.DW(DW), .OP_GROUP(OP_GROUP)) u_cond (
      .opcode  (opcode),
      .acc     (acc),
      .carry   (carry),
      .qlat    (qlat),
      .is_jump (is_jump),
      .take    (take)
   );

   lbr_fsm #(.NB(NB)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (start && is_jump),
      .take_in (take),
      .busy    (busy),
      .last    (last),
      .taken   (taken),
      .idx     (idx)
   );

   lbr_pcdrv #(.NB(NB), .DW(DW)) u_pc (
      .busy     (busy),
      .taken    (taken),
      .idx      (idx),
      .mem_data (mem_data),
      .pc_ld    (pc_ld),
      .pc_wdata (pc_wdata),
      .pc_inc   (pc_inc)
   );

   assign done = last;

endmodule

// File: rtl/lbr_seq_chk.sv
module lbr_seq_chk #(
   parameter int         NB       = 2,
   parameter logic [3:0] OP_GROUP = 4'hC
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [7:0]    opcode,
   input logic [NB-1:0] pc_ld,
   input logic          pc_inc,
   input logic          busy,
   input logic          done
);

   logic grp;
   assign grp = (opcode[7:4] == OP_GROUP) && !opcode[2];

   assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_ld, pc_inc}));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pc_ld == '0 && !pc_inc && !done));

   assert_start_goes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && grp) |=> (busy && !done));

   assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !grp) |=> !busy);

   assert_hold_ld_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && pc_ld != '0) |=> (pc_ld != '0));

   assert_hold_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && pc_inc) |=> pc_inc);

   assert_busy_acts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pc_inc || pc_ld != '0));

endmodule

bind lbr_seq lbr_seq_chk #(.NB(NB), .OP_GROUP(OP_GROUP)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .opcode (opcode),
   .pc_ld  (pc_ld),
   .pc_inc (pc_inc),
   .busy   (busy),
   .done   (done)
);

// File: tb/sim_lbr_seq.sv
`timescale 1ns/1ps
module sim_lbr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  mem_data = 8'h00;
   logic [7:0]  acc = 8'h00;
   logic        carry = 1'b0;
   logic        qlat = 1'b0;
   logic [1:0]  pc_ld;
   logic [7:0]  pc_wdata;
   logic        pc_inc;
   logic        busy;
   logic        done;

   int total = 0;
   int bad = 0;
   logic [15:0] pc_m;

   always #2.5 clk = ~clk;

   lbr_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .mem_data(mem_data), .acc(acc), .carry(carry), .qlat(qlat),
      .pc_ld(pc_ld), .pc_wdata(pc_wdata), .pc_inc(pc_inc),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_take(input logic [7:0] op, input logic [7:0] a,
                                   input logic c, input logic q);
      bit r;
      case (op[1:0])
         2'b00: r = 1'b1;
         2'b01: r = q;
         2'b10: r = (a == 8'h00);
         default: r = c;
      endcase
      return r ^ op[3];
   endfunction

   function automatic logic [15:0] apply(input logic [15:0] p);
      logic [15:0] n = p;
      if (pc_ld[1]) n[15:8] = pc_wdata;
      if (pc_ld[0]) n[7:0]  = pc_wdata;
      if (pc_inc)   n = n + 16'd1;
      return n;
   endfunction

   task automatic run_jump(input logic [7:0] op, input logic [7:0] a, input logic c,
                           input logic q, input logic [15:0] addr,
                           input logic [7:0] hi, input logic [7:0] lo, input bit hold_start);
      bit t = exp_take(op, a, c, q);
      logic [15:0] want = t ? {hi, lo} : addr + 16'd3;
      @(negedge clk);
      start = 1'b1; opcode = op; acc = a; carry = c; qlat = q; mem_data = hi;
      pc_m = addr + 16'd1;
      @(negedge clk);
      start = hold_start; opcode = 8'hC0;
      acc = ~a; carry = ~c; qlat = ~q;
      // R2 / R4 / R5 / R6: first execute cycle
      chk(busy === 1'b1 && done === 1'b0, "R2 first busy cycle", {busy, done}, 2'b10);
      chk(pc_ld === (t ? 2'b10 : 2'b00) && pc_inc === !t, t ? "R4 high load" : "R5 first inc",
          {pc_ld, pc_inc}, t ? 3'b100 : 3'b001);
      if (t) chk(pc_wdata === hi, "R4 high data", pc_wdata, hi);
      pc_m = apply(pc_m);
      mem_data = lo;
      @(negedge clk);
      // second execute cycle
      chk(busy === 1'b1 && done === 1'b1, "R2 second busy cycle done", {busy, done}, 2'b11);
      chk(pc_ld === (t ? 2'b01 : 2'b00) && pc_inc === !t, t ? "R4 low load" : "R5 second inc",
          {pc_ld, pc_inc}, t ? 3'b010 : 3'b001);
      if (t) chk(pc_wdata === lo, "R4 low data", pc_wdata, lo);
      pc_m = apply(pc_m);
      chk(pc_m === want, t ? "R3 taken target" : "R3 skip target", pc_m, want);
      start = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, hold_start ? "R8 back to idle" : "R2 back to idle",
          {busy, done}, 2'b00);
   endtask

   task automatic run_reject(input logic [7:0] op);
      @(negedge clk);
      start = 1'b1; opcode = op;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0 && pc_ld === 2'b00 && pc_inc === 1'b0, "R7 rejected opcode",
          {busy, pc_ld, pc_inc}, 0);
   endtask

   initial begin
      #1;
      chk(busy === 1'b0 && done === 1'b0 && pc_ld === 2'b00 && pc_inc === 1'b0,
          "R1 reset state", {busy, done, pc_ld, pc_inc}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(busy === 1'b0 && done === 1'b0 && pc_ld === 2'b00 && pc_inc === 1'b0,
          "R1 idle after reset", {busy, done, pc_ld, pc_inc}, 0);
      for (int oi = 0; oi < 8; oi++) begin
         for (int ai = 0; ai < 4; ai++) begin
            for (int f = 0; f < 4; f++) begin
               logic [7:0] op = 8'hC0 | 8'((oi & 3) | ((oi >> 2) << 3));
               logic [7:0] a  = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h01 : (ai == 2) ? 8'h80 : 8'hFF;
               logic [15:0] addr = 16'h1000 + 16'((oi * 16 + ai * 4 + f) * 37);
               run_jump(op, a, f[0], f[1], addr, 8'(oi * 29 + 3), 8'(ai * 53 + f + 7), 1'b0);
            end
         end
      end
      // skip wraps past the top of memory (R5)
      run_jump(8'hC8, 8'h00, 1'b0, 1'b0, 16'hFFFE, 8'h12, 8'h34, 1'b0);
      run_jump(8'hC8, 8'h00, 1'b0, 1'b0, 16'hFFFF, 8'h12, 8'h34, 1'b0);
      // start held during the sequence (R8)
      run_jump(8'hC0, 8'h05, 1'b0, 1'b0, 16'h2000, 8'hAB, 8'hCD, 1'b1);
      run_jump(8'hCA, 8'h05, 1'b0, 1'b0, 16'h3000, 8'hAB, 8'hCD, 1'b1);
      // rejected opcodes (R7)
      run_reject(8'hC4);
      run_reject(8'hCF);
      run_reject(8'h30);
      run_reject(8'hD0);
      run_reject(8'h40);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule